// File: doc/BRIEF.md
# Coprocessor Mailbox and Boot Controller

This block is a small register file between a host bus and an embedded video coprocessor. The host uses it to take the coprocessor through reset and start-up, to exchange interrupts and a scratch word with it, and to hand it work. Work is handed over as a command pointer. The host writes the pending pointer, and a vsync event promotes it to the current pointer that the coprocessor executes. A zero pointer means there is no work.

Start-up happens in stages that the host can see. A reset request holds the coprocessor in reset for a fixed number of clocks and then raises a done flag. The host then authorises idle mode and enables instruction fetch. The coprocessor acknowledges the end of its boot on a handshake pin. From that point the block reports it as ready while the current pointer is zero and as processing while the pointer is nonzero. A two-bit vsync-source register chooses how promotion is triggered: by the rising edge of the hardware vsync, by the host's own pointer write, or not at all.

The host bus is a simple single-cycle strobe interface with a byte address. Read data is combinational and is zero whenever no read is in progress.

Top module: `cpmbx_top`

## Requirements
- R1: After the asynchronous reset, every register reads zero, `cp_core_rst` is 1 and `cp_fetch_en` is 0. The coprocessor stays in reset until the host requests a reset.
- R2: A write to offset 0x10 with bit 0 or bit 1 set clears the reset-done flag (bit 0 of offset 0x14) and asserts `cp_core_rst`. Exactly RST_CYCLES clocks after the request edge, the flag reads 1 and `cp_core_rst` drops. A write with neither bit set has no effect.
- R3: A full reset request (bit 0 of offset 0x10) also clears the pending and current command pointers and the idle authorisation. A core-only request (bit 1 alone) keeps both pointers and the idle authorisation. Both kinds clear fetch enable and the boot acknowledgement.
- R4: Bit 2 of offset 0x14 (idle authorisation) is read/write. Bit 0 of that offset is read-only.
- R5: Bit 1 of offset 0x18 (fetch enable, driven on `cp_fetch_en`) takes a written 1 only while reset-done and idle authorisation are both 1. Otherwise that write is ignored. Writing 0 always clears it.
- R6: At offset 0x0C, bit 13 reads 1 while fetch is enabled and boot is not yet acknowledged. A `cp_boot_done` pulse records the acknowledgement. After that, bit 15 reads 1 while the current pointer is zero and bit 14 reads 1 while it is nonzero. All other bits read 0.
- R7: With vsync source 0 at offset 0x28, a rising edge on `hw_vsync` copies the pending pointer (offset 0x20) into the current pointer (offset 0x24, `cp_cur_cmd`) at that clock edge and pulses `cp_vsync` for one cycle. A level that stays high does not promote again.
- R8: With vsync source 1, `hw_vsync` is ignored, and each write to offset 0x20 also loads the current pointer at the same edge.
- R9: With vsync source 2 or 3, no promotion takes place.
- R10: Writing 1 to bit 0 of offset 0x00 gives a one-cycle pulse on `irq_to_cp`, and that offset reads 0. A `cp_host_irq` pulse sets bit 0 of offset 0x08 and `irq_to_host`. Writing 1 to that bit clears it, but a simultaneous `cp_host_irq` wins.
- R11: Offset 0x04 is a read/write word mirrored on `cp_host_info`. Offset 0x1C reads `cp_gp_status`. Writes to 0x0C, 0x1C and 0x24 are ignored. Unmapped or misaligned addresses read 0, and writes to them have no effect.
- R12: `bus_rdata` is zero whenever no read is being made (`bus_sel` low or `bus_wr` high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Host access strobe |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, combinational |
| hw_vsync | input | 1 | Hardware vsync level |
| cp_boot_done | input | 1 | Coprocessor boot acknowledgement pulse |
| cp_host_irq | input | 1 | Coprocessor interrupt request to host |
| cp_gp_status | input | DW | Coprocessor general status word |
| cp_core_rst | output | 1 | Reset held on the coprocessor |
| cp_idle_ok | output | 1 | Idle mode authorised |
| cp_fetch_en | output | 1 | Instruction fetch enable |
| cp_vsync | output | 1 | One-cycle pulse on command promotion |
| cp_cur_cmd | output | DW | Current command pointer |
| cp_host_info | output | DW | Host-to-coprocessor info word |
| irq_to_cp | output | 1 | Interrupt pulse to coprocessor |
| irq_to_host | output | 1 | Sticky interrupt to host |

## Verification
The bench builds the block with RST_CYCLES = 6, ADDR_W = 8 and DW = 32. The short reset window lets the bench count the done latency to the exact clock and still run several full and core-only resets. The 8-bit address space covers every unmapped and misaligned offset up to 0xFF, which the random phase probes alongside random pointer writes, vsync pulses and writes to read-only registers. The 32-bit width lets random pointers reach full-width values and zero, so both the ready and the processing outcomes occur.

// File: rtl/cpmbx_pkg.sv
package cpmbx_pkg;
  // register slots, index = byte offset / 4
  localparam int NREG      = 11;
  localparam int IX_IRQCP  = 0;
  localparam int IX_HINFO  = 1;
  localparam int IX_IRQH   = 2;
  localparam int IX_CPINFO = 3;
  localparam int IX_SRST   = 4;
  localparam int IX_START1 = 5;
  localparam int IX_START2 = 6;
  localparam int IX_GPSTAT = 7;
  localparam int IX_NEXT   = 8;
  localparam int IX_CUR    = 9;
  localparam int IX_VSMODE = 10;

  // bit positions decoded by the coprocessor side
  localparam int SRST_FULL_BIT  = 0;
  localparam int SRST_CORE_BIT  = 1;
  localparam int ST1_DONE_BIT   = 0;
  localparam int ST1_IDLE_BIT   = 2;
  localparam int ST2_FETCH_BIT  = 1;
  localparam int INFO_READY_BIT = 15;
  localparam int INFO_PROC_BIT  = 14;
  localparam int INFO_INITQ_BIT = 13;

  typedef enum logic [1:0] {
    VS_HW     = 2'd0,
    VS_SWCMD  = 2'd1,
    VS_HOLD   = 2'd2,
    VS_SWMASK = 2'd3
  } vs_src_e;
endpackage

// File: rtl/cpmbx_decode.sv
module cpmbx_decode #(
  parameter int ADDR_W = 8,
  parameter int NREG   = 11
) (
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic [NREG-1:0]   wr_hit,
  output logic [NREG-1:0]   rd_hit
);
  logic [NREG-1:0] match;

  genvar gi;
  generate
    for (gi = 0; gi < NREG; gi++) begin : g_slot
      assign match[gi]  = (bus_addr == ADDR_W'(gi * 4));
      assign wr_hit[gi] = bus_sel & bus_wr & match[gi];
      assign rd_hit[gi] = bus_sel & ~bus_wr & match[gi];
    end
  endgenerate
endmodule

// File: rtl/cpmbx_rst_seq.sv
module cpmbx_rst_seq #(
  parameter int RST_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       srst_we,
  input  logic [1:0] srst_bits,
  input  logic       st1_we,
  input  logic       idle_wbit,
  input  logic       st2_we,
  input  logic       fetch_wbit,
  input  logic       cp_boot_done,
  output logic       rst_done,
  output logic       core_rst,
  output logic       idle_auth,
  output logic       fetch_en,
  output logic       booted,
  output logic       full_clr
);
  import cpmbx_pkg::*;

  localparam int CNT_W = (RST_CYCLES < 2) ? 1 : $clog2(RST_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RST_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic busy_q, busy_d;
  logic done_q, done_d;
  logic idle_q, idle_d;
  logic fetch_q, fetch_d;
  logic boot_q, boot_d;
  logic req, req_full;

  assign req      = srst_we & (srst_bits[SRST_FULL_BIT] | srst_bits[SRST_CORE_BIT]);
  assign req_full = srst_we & srst_bits[SRST_FULL_BIT];

  always_comb begin
    cnt_d   = cnt_q;
    busy_d  = busy_q;
    done_d  = done_q;
    idle_d  = idle_q;
    fetch_d = fetch_q;
    boot_d  = boot_q;

    if (st1_we) idle_d = idle_wbit;

    if (st2_we) begin
      if (fetch_wbit) begin
        if (done_q && idle_q) fetch_d = 1'b1;
      end else begin
        fetch_d = 1'b0;
        boot_d  = 1'b0;
      end
    end

    if (fetch_q && cp_boot_done) boot_d = 1'b1;

    if (busy_q) begin
      if (cnt_q == '0) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end

    if (req) begin
      cnt_d   = CNT_LOAD;
      busy_d  = 1'b1;
      done_d  = 1'b0;
      fetch_d = 1'b0;
      boot_d  = 1'b0;
      if (req_full) idle_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      idle_q  <= 1'b0;
      fetch_q <= 1'b0;
      boot_q  <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      busy_q  <= busy_d;
      done_q  <= done_d;
      idle_q  <= idle_d;
      fetch_q <= fetch_d;
      boot_q  <= boot_d;
    end
  end

  assign rst_done  = done_q;
  assign core_rst  = busy_q | ~done_q;
  assign idle_auth = idle_q;
  assign fetch_en  = fetch_q;
  assign booted    = boot_q;
  assign full_clr  = req_full;
endmodule

// File: rtl/cpmbx_cmd_pipe.sv
module cpmbx_cmd_pipe #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    vs_src,
  input  logic          hw_vsync,
  input  logic          next_we,
  input  logic [DW-1:0] next_wdata,
  input  logic          clr,
  output logic [DW-1:0] next_cmd,
  output logic [DW-1:0] cur_cmd,
  output logic          vs_pulse
);
  import cpmbx_pkg::*;

  logic [DW-1:0] next_q, next_d;
  logic [DW-1:0] cur_q, cur_d;
  logic vs_q;
  logic pulse_q, pulse_d;
  logic hw_prom, sw_prom;

  assign hw_prom = (vs_src == VS_HW) & hw_vsync & ~vs_q;
  assign sw_prom = (vs_src == VS_SWCMD) & next_we;

  always_comb begin
    next_d  = next_q;
    cur_d   = cur_q;
    pulse_d = 1'b0;
    if (clr) begin
      next_d = '0;
      cur_d  = '0;
    end else begin
      if (next_we) next_d = next_wdata;
      if (sw_prom) begin
        cur_d   = next_wdata;
        pulse_d = 1'b1;
      end else if (hw_prom) begin
        cur_d   = next_q;
        pulse_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      next_q  <= '0;
      cur_q   <= '0;
      vs_q    <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      next_q  <= next_d;
      cur_q   <= cur_d;
      vs_q    <= hw_vsync;
      pulse_q <= pulse_d;
    end
  end

  assign next_cmd = next_q;
  assign cur_cmd  = cur_q;
  assign vs_pulse = pulse_q;
endmodule

// File: rtl/cpmbx_top.sv
module cpmbx_top #(
  parameter int ADDR_W     = 8,
  parameter int DW         = 32,
  parameter int RST_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              hw_vsync,
  input  logic              cp_boot_done,
  input  logic              cp_host_irq,
  input  logic [DW-1:0]     cp_gp_status,
  output logic              cp_core_rst,
  output logic              cp_idle_ok,
  output logic              cp_fetch_en,
  output logic              cp_vsync,
  output logic [DW-1:0]     cp_cur_cmd,
  output logic [DW-1:0]     cp_host_info,
  output logic              irq_to_cp,
  output logic              irq_to_host
);
  import cpmbx_pkg::*;

  logic [NREG-1:0] wr_hit, rd_hit;
  logic rst_done, idle_auth, fetch_en, booted, full_clr, core_rst;
  logic [DW-1:0] next_cmd, cur_cmd;
  logic vs_pulse;

  logic          irqcp_q, irqcp_d;
  logic          irqh_q, irqh_d;
  logic [DW-1:0] hinfo_q, hinfo_d;
  logic [1:0]    vsrc_q, vsrc_d;
  logic [DW-1:0] info_word;
  logic [DW-1:0] view [NREG];
  logic [DW-1:0] rdata_mux;

  cpmbx_decode #(.ADDR_W(ADDR_W), .NREG(NREG)) u_dec (
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .wr_hit   (wr_hit),
    .rd_hit   (rd_hit)
  );

  cpmbx_rst_seq #(.RST_CYCLES(RST_CYCLES)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .srst_we      (wr_hit[IX_SRST]),
    .srst_bits    (bus_wdata[1:0]),
    .st1_we       (wr_hit[IX_START1]),
    .idle_wbit    (bus_wdata[ST1_IDLE_BIT]),
    .st2_we       (wr_hit[IX_START2]),
    .fetch_wbit   (bus_wdata[ST2_FETCH_BIT]),
    .cp_boot_done (cp_boot_done),
    .rst_done     (rst_done),
    .core_rst     (core_rst),
    .idle_auth    (idle_auth),
    .fetch_en     (fetch_en),
    .booted       (booted),
    .full_clr     (full_clr)
  );

  cpmbx_cmd_pipe #(.DW(DW)) u_cmd (
    .clk        (clk),
    .rst_n      (rst_n),
    .vs_src     (vsrc_q),
    .hw_vsync   (hw_vsync),
    .next_we    (wr_hit[IX_NEXT]),
    .next_wdata (bus_wdata),
    .clr        (full_clr),
    .next_cmd   (next_cmd),
    .cur_cmd    (cur_cmd),
    .vs_pulse   (vs_pulse)
  );

  // small local registers: interrupts, info word, vsync source
  always_comb begin
    irqcp_d = wr_hit[IX_IRQCP] & bus_wdata[0];
    irqh_d  = irqh_q;
    if (wr_hit[IX_IRQH] && bus_wdata[0]) irqh_d = 1'b0;
    if (cp_host_irq) irqh_d = 1'b1;
    hinfo_d = wr_hit[IX_HINFO] ? bus_wdata : hinfo_q;
    vsrc_d  = wr_hit[IX_VSMODE] ? bus_wdata[1:0] : vsrc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irqcp_q <= 1'b0;
      irqh_q  <= 1'b0;
      hinfo_q <= '0;
      vsrc_q  <= VS_HW;
    end else begin
      irqcp_q <= irqcp_d;
      irqh_q  <= irqh_d;
      hinfo_q <= hinfo_d;
      vsrc_q  <= vsrc_d;
    end
  end

  always_comb begin
    info_word = '0;
    info_word[INFO_READY_BIT] = booted & (cur_cmd == '0);
    info_word[INFO_PROC_BIT]  = booted & (cur_cmd != '0);
    info_word[INFO_INITQ_BIT] = fetch_en & ~booted;
  end

  always_comb begin
    for (int i = 0; i < NREG; i++) view[i] = '0;
    view[IX_HINFO]  = hinfo_q;
    view[IX_IRQH]   = DW'(irqh_q);
    view[IX_CPINFO] = info_word;
    view[IX_START1][ST1_DONE_BIT]  = rst_done;
    view[IX_START1][ST1_IDLE_BIT]  = idle_auth;
    view[IX_START2][ST2_FETCH_BIT] = fetch_en;
    view[IX_GPSTAT] = cp_gp_status;
    view[IX_NEXT]   = next_cmd;
    view[IX_CUR]    = cur_cmd;
    view[IX_VSMODE] = DW'(vsrc_q);
  end

  always_comb begin
    rdata_mux = '0;
    for (int i = 0; i < NREG; i++) begin
      if (rd_hit[i]) rdata_mux = rdata_mux | view[i];
    end
  end

  assign bus_rdata    = rdata_mux;
  assign cp_core_rst  = core_rst;
  assign cp_idle_ok   = idle_auth;
  assign cp_fetch_en  = fetch_en;
  assign cp_vsync     = vs_pulse;
  assign cp_cur_cmd   = cur_cmd;
  assign cp_host_info = hinfo_q;
  assign irq_to_cp    = irqcp_q;
  assign irq_to_host  = irqh_q;
endmodule

// File: rtl/cpmbx_chk.sv
module cpmbx_chk #(
  parameter int ADDR_W = 8,
  parameter int DW     = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [1:0]        wd_lo,
  input logic [DW-1:0]     bus_rdata,
  input logic              cp_host_irq,
  input logic              cp_core_rst,
  input logic              cp_fetch_en,
  input logic              cp_vsync,
  input logic [DW-1:0]     cp_cur_cmd,
  input logic              irq_to_cp,
  input logic              irq_to_host
);
  logic wr_srst, wr_irqcp;
  assign wr_srst  = bus_sel & bus_wr & (bus_addr == ADDR_W'(16)) & (wd_lo != 2'b00);
  assign wr_irqcp = bus_sel & bus_wr & (bus_addr == ADDR_W'(0)) & wd_lo[0];

  // R2
  core_rst_on_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_srst |=> cp_core_rst);

  // R5
  fetch_outside_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cp_fetch_en |-> !cp_core_rst);

  // R7
  cur_moves_on_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_cur_cmd != $past(cp_cur_cmd)) |-> (cp_vsync || cp_core_rst));

  // R10
  irq_cp_from_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_to_cp |-> $past(wr_irqcp));

  // R10
  host_irq_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cp_host_irq |=> irq_to_host);

  // R12
  idle_rdata_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && !bus_wr) |-> (bus_rdata == '0));
endmodule

bind cpmbx_top cpmbx_chk #(.ADDR_W(ADDR_W), .DW(DW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_sel     (bus_sel),
  .bus_wr      (bus_wr),
  .bus_addr    (bus_addr),
  .wd_lo       (bus_wdata[1:0]),
  .bus_rdata   (bus_rdata),
  .cp_host_irq (cp_host_irq),
  .cp_core_rst (cp_core_rst),
  .cp_fetch_en (cp_fetch_en),
  .cp_vsync    (cp_vsync),
  .cp_cur_cmd  (cp_cur_cmd),
  .irq_to_cp   (irq_to_cp),
  .irq_to_host (irq_to_host)
);

// File: tb/tb_cpmbx_top.sv
module tb_cpmbx_top;
  localparam int AW  = 8;
  localparam int DW  = 32;
  localparam int RST = 6;

  logic clk, rst_n;
  logic bus_sel, bus_wr;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;
  logic hw_vsync, cp_boot_done, cp_host_irq;
  logic [DW-1:0] cp_gp_status;
  logic cp_core_rst, cp_idle_ok, cp_fetch_en, cp_vsync, irq_to_cp, irq_to_host;
  logic [DW-1:0] cp_cur_cmd, cp_host_info;

  int n_tests = 0;
  int n_fail  = 0;

  cpmbx_top #(.ADDR_W(AW), .DW(DW), .RST_CYCLES(RST)) dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .hw_vsync(hw_vsync), .cp_boot_done(cp_boot_done), .cp_host_irq(cp_host_irq),
    .cp_gp_status(cp_gp_status), .cp_core_rst(cp_core_rst), .cp_idle_ok(cp_idle_ok),
    .cp_fetch_en(cp_fetch_en), .cp_vsync(cp_vsync), .cp_cur_cmd(cp_cur_cmd),
    .cp_host_info(cp_host_info), .irq_to_cp(irq_to_cp), .irq_to_host(irq_to_host)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] v);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 v = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic vs_pulse();
    hw_vsync = 1'b1;
    @(posedge clk); #1;
    hw_vsync = 1'b0;
    @(posedge clk); #1;
  endtask

  function automatic logic [DW-1:0] exp_info(input logic [DW-1:0] cur);
    return (cur == '0) ? 32'h0000_8000 : 32'h0000_4000;
  endfunction

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [DW-1:0] v, m_next, m_cur, x;
    int cyc;
    void'($urandom(32'h1D5E_ED01));
    bus_sel = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
    hw_vsync = 0; cp_boot_done = 0; cp_host_irq = 0; cp_gp_status = '0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #1;

    // R1 reset state
    for (int a = 0; a < 11; a++) begin
      rd(AW'(a * 4), v);
      chk($sformatf("R1 reg 0x%02h after reset", a * 4), v, '0);
    end
    chk("R1 core reset held", cp_core_rst, 1);
    chk("R1 fetch off", cp_fetch_en, 0);

    // R5 fetch before any reset done
    wr(8'h18, 32'h2); rd(8'h18, v);
    chk("R5 fetch refused before reset", v, 0);

    // R2 request without bits
    wr(8'h10, 32'h0); rd(8'h14, v);
    chk("R2 empty request no effect", v, 0);
    chk("R2 empty request core rst", cp_core_rst, 1);

    // R2 full reset latency
    wr(8'h10, 32'h1);
    chk("R2 core rst during count", cp_core_rst, 1);
    cyc = 0;
    rd(8'h14, v);
    while (v[0] == 1'b0 && cyc < 50) begin
      @(posedge clk); #1;
      cyc++;
      rd(8'h14, v);
    end
    chk("R2 done latency", cyc, RST);
    chk("R2 core rst released", cp_core_rst, 0);
    wr(8'h10, 32'h0); rd(8'h14, v);
    chk("R2 empty request keeps done", v, 32'h1);

    // R5 fetch without idle authorisation
    wr(8'h18, 32'h2); rd(8'h18, v);
    chk("R5 fetch refused without idle", v, 0);
    // R4 idle bit rw, done bit ro
    wr(8'h14, 32'h4); rd(8'h14, v);
    chk("R4 idle set", v, 32'h5);
    chk("R4 idle pin", cp_idle_ok, 1);
    wr(8'h14, 32'h1); rd(8'h14, v);
    chk("R4 done read-only, idle cleared", v, 32'h1);
    wr(8'h14, 32'h4);

    // R5 fetch accepted
    wr(8'h18, 32'h2); rd(8'h18, v);
    chk("R5 fetch accepted", v, 32'h2);
    chk("R5 fetch pin", cp_fetch_en, 1);
    rd(8'h0C, v);
    chk("R6 init queues", v, 32'h2000);
    cp_boot_done = 1; @(posedge clk); #1; cp_boot_done = 0;
    rd(8'h0C, v);
    chk("R6 ready after boot", v, 32'h8000);

    // R7 hardware vsync promotion
    wr(8'h20, 32'h1234_5678);
    chk("R7 no promotion on write", cp_cur_cmd, 0);
    hw_vsync = 1; @(posedge clk); #1;
    chk("R7 promoted on edge", cp_cur_cmd, 32'h1234_5678);
    chk("R7 vsync pulse", cp_vsync, 1);
    wr(8'h20, 32'h9);
    chk("R7 held level no promote", cp_cur_cmd, 32'h1234_5678);
    chk("R7 pulse one cycle", cp_vsync, 0);
    hw_vsync = 0; @(posedge clk); #1;
    rd(8'h0C, v);
    chk("R6 processing", v, 32'h4000);
    m_next = 32'h9; m_cur = 32'h1234_5678;

    // random phase, vsync source 0
    for (int it = 0; it < 300; it++) begin
      case ($urandom % 5)
        0: begin
          m_next = ($urandom % 4 == 0) ? '0 : $urandom;
          wr(8'h20, m_next);
        end
        1: begin vs_pulse(); m_cur = m_next; end
        2: begin
          if ($urandom % 2) x = AW'(8'h2C + 4 * ($urandom % 53));
          else x = AW'((4 * ($urandom % 11)) | (1 + $urandom % 3));
          rd(x[AW-1:0], v);
          chk("R11 unmapped read zero", v, 0);
          wr(x[AW-1:0], $urandom);
        end
        3: begin
          case ($urandom % 3)
            0: x = 32'h0C;
            1: x = 32'h1C;
            default: x = 32'h24;
          endcase
          wr(x[AW-1:0], $urandom);
        end
        default: begin
          cp_gp_status = $urandom;
          rd(8'h1C, v);
          chk("R11 gp status", v, cp_gp_status);
        end
      endcase
      rd(8'h24, v);
      chk("R7 random current", v, m_cur);
      rd(8'h20, v);
      chk("R11 random next", v, m_next);
      rd(8'h0C, v);
      chk("R6 random info", v, exp_info(m_cur));
    end

    // R6 return to idle with zero command
    wr(8'h20, 32'h0); vs_pulse();
    rd(8'h0C, v);
    chk("R6 ready on zero command", v, 32'h8000);

    // R9 / R8 source modes
    wr(8'h20, 32'h11); vs_pulse();
    chk("R7 promote 0x11", cp_cur_cmd, 32'h11);
    wr(8'h28, 32'h3); wr(8'h20, 32'h22); vs_pulse();
    chk("R9 mode 3 holds", cp_cur_cmd, 32'h11);
    wr(8'h28, 32'h2); vs_pulse();
    chk("R9 mode 2 holds", cp_cur_cmd, 32'h11);
    wr(8'h28, 32'h1); rd(8'h28, v);
    chk("R8 mode reads back", v, 32'h1);
    vs_pulse();
    chk("R8 hw vsync ignored", cp_cur_cmd, 32'h11);
    wr(8'h20, 32'h33);
    chk("R8 write promotes", cp_cur_cmd, 32'h33);

    // R10 interrupts
    bus_sel = 1; bus_wr = 1; bus_addr = 8'h00; bus_wdata = 32'h1;
    @(posedge clk); #1; bus_sel = 0; bus_wr = 0;
    chk("R10 irq to cp pulse", irq_to_cp, 1);
    @(posedge clk); #1;
    chk("R10 irq to cp ends", irq_to_cp, 0);
    rd(8'h00, v);
    chk("R10 irq reg reads zero", v, 0);
    wr(8'h00, 32'h0);
    chk("R10 zero write no pulse", irq_to_cp, 0);
    cp_host_irq = 1; @(posedge clk); #1; cp_host_irq = 0;
    rd(8'h08, v);
    chk("R10 host irq set", v, 1);
    chk("R10 host irq pin", irq_to_host, 1);
    cp_host_irq = 1; wr(8'h08, 32'h1); cp_host_irq = 0;
    chk("R10 set wins over clear", irq_to_host, 1);
    wr(8'h08, 32'h1);
    chk("R10 host irq cleared", irq_to_host, 0);

    // R11 host info and read-only status
    wr(8'h04, 32'hDEAD_BEEF); rd(8'h04, v);
    chk("R11 host info rw", v, 32'hDEAD_BEEF);
    chk("R11 host info pin", cp_host_info, 32'hDEAD_BEEF);
    cp_gp_status = 32'h0000_55AA; wr(8'h1C, 32'hFFFF_FFFF); rd(8'h1C, v);
    chk("R11 gp status read-only", v, 32'h0000_55AA);

    // R12 no read in progress
    bus_sel = 0; bus_wr = 0; bus_addr = 8'h04; #1;
    chk("R12 idle rdata", bus_rdata, 0);
    bus_sel = 1; bus_wr = 1; bus_addr = 8'h04; bus_wdata = 32'hDEAD_BEEF; #1;
    chk("R12 write rdata", bus_rdata, 0);
    @(posedge clk); #1; bus_sel = 0; bus_wr = 0;

    // R3 core-only reset
    wr(8'h10, 32'h2);
    chk("R3 core reset stops fetch", cp_fetch_en, 0);
    rd(8'h14, v);
    chk("R3 core reset keeps idle", v, 32'h4);
    rd(8'h20, v);
    chk("R3 core reset keeps next", v, 32'h33);
    rd(8'h0C, v);
    chk("R3 boot ack cleared", v, 0);
    repeat (RST) @(posedge clk);
    #1 rd(8'h14, v);
    chk("R2 core reset done", v, 32'h5);

    // R3 full reset
    wr(8'h10, 32'h3);
    rd(8'h20, v);
    chk("R3 full clears next", v, 0);
    chk("R3 full clears current", cp_cur_cmd, 0);
    rd(8'h14, v);
    chk("R3 full clears idle", v, 0);

    finish_run();
  end
endmodule